// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register side of a 16550-compatible serial port. A host reaches eight byte-wide registers through a 3-bit offset and separate read and write strobes. The block keeps the divisor latches, the interrupt enable, FIFO control, line control and scratch registers. A data write queues a byte in a transmit FIFO, which a downstream shifter drains through a pop port. A data read takes a byte from a receive FIFO, which an upstream shifter fills through a push port.

Line status and interrupt identification are built from live state. Reads of these registers have side effects: they clear the overrun flag or the latched transmit-empty cause. A single interrupt line shows whether any enabled cause is pending. A configuration input sets its active level.

Read data is registered. It is valid in the cycle after the read strobe. State changes caused by an access take effect at the same clock edge, so the interrupt line reflects them from the next cycle on. Only one access is made per cycle. When both strobes are high, the write is taken.

Top module: `uart_regfront`

## Requirements
- R1: While LCR bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes. The data FIFOs and the interrupt enable register are not touched.
- R2: A write to offset 0 (LCR bit 7 clear) appends the byte to the transmit FIFO. `tx_data` shows the oldest byte while `tx_empty` is low, and `tx_pop` removes it. The write also latches a transmit-empty interrupt cause.
- R3: The interrupt enable register at offset 1 stores bits 3:0 only. Bits 7:4 read as zero.
- R4: A write to offset 2 with bit 0 clear disables the FIFOs. With bit 0 set, the FIFOs are enabled, and if bit 1 is also set the receive FIFO is emptied.
- R5: The cause is chosen in a fixed priority. Overrun with enable bit 2 gives 0x06. Otherwise a non-empty receive FIFO with enable bit 0 gives 0x0C. Otherwise the latched transmit-empty cause with enable bit 1 gives 0x02. Otherwise the code is 0x01.
- R6: A read of offset 2 returns the cause code, with bits 7:6 set while the FIFOs are enabled. A read that reports 0x02 clears the latched transmit-empty cause.
- R7: A read of offset 0 (LCR bit 7 clear) returns and removes the oldest received byte, or returns 0xFF when the FIFO is empty. It also clears the overrun flag.
- R8: A read of offset 5 returns bit 6 and bit 5 set, bit 1 as overrun and bit 0 as receive data present. It then clears the overrun flag.
- R9: Offset 6 reads 0. Offset 4 reads 0 and ignores writes. Writes to offsets 5 and 6 have no effect. Offset 7 is a plain read/write byte.
- R10: `irq` is at its active level whenever the cause code is not 0x01. It is high-active when `irq_pol_low` is 0 and low-active when it is 1.
- R11: After reset the divisor latches hold CLK_HZ/(16*9600), split into a low byte and a high byte. LCR, the interrupt enables and FIFO control are zero.
- R12: A byte pushed into a full receive FIFO is dropped and sets the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pol_low | input | 1 | 1 selects a low-active interrupt line |
| sel | input | 1 | Access select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after the read |
| irq | output | 1 | Interrupt line |
| tx_pop | input | 1 | Remove the oldest transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_push | input | 1 | Append `rx_byte` to the receive FIFO |
| rx_byte | input | 8 | Received byte |

## Verification
Read results appear on `rdata` one cycle after the read strobe. The driver queues the expected byte when it issues a read. The monitor compares the queued byte at the falling edge that follows the capturing rising edge. Interrupt line and transmit port changes become visible in the cycle after the access or push that causes them, so those checks are sampled at the falling edge that ends the stimulating task.

// File: rtl/uart_regfront.sv
module uart_regfront #(
  parameter int CLK_HZ   = 1843200,
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_pol_low,
  input  logic       sel,
  input  logic       wr,
  input  logic       rd,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       tx_pop,
  output logic [7:0] tx_data,
  output logic       tx_empty,
  input  logic       rx_push,
  input  logic [7:0] rx_byte
);
  localparam int TXW = $clog2(TX_DEPTH);
  localparam int RXW = $clog2(RX_DEPTH);
  localparam logic [15:0] DIV0 = 16'(CLK_HZ / (16 * 9600));
  localparam logic [7:0] C_LINE = 8'h06, C_RXD = 8'h0C, C_THRE = 8'h02, C_NONE = 8'h01;

  logic [7:0] dll_q, dlm_q, lcr_q, scr_q, fcr_q;
  logic [3:0] ier_q;
  logic       ovr_q, thre_q;

  logic [7:0]   tx_mem [TX_DEPTH];
  logic [TXW-1:0] tx_wp, tx_rp;
  logic [TXW:0]   tx_cnt;
  logic [7:0]   rx_mem [RX_DEPTH];
  logic [RXW-1:0] rx_wp, rx_rp;
  logic [RXW:0]   rx_cnt;

  wire dlab   = lcr_q[7];
  wire acc_wr = sel & wr;
  wire acc_rd = sel & rd & ~wr;
  wire data_rd = acc_rd & addr == 3'd0 & ~dlab;

  wire tx_wr   = acc_wr & addr == 3'd0 & ~dlab;
  wire tx_full = tx_cnt == (TXW+1)'(TX_DEPTH);
  wire tx_out  = tx_pop & tx_cnt != '0;
  wire tx_inc  = tx_wr & (~tx_full | tx_out);
  wire tx_drop = tx_wr & tx_full & ~tx_out;

  wire rx_full  = rx_cnt == (RXW+1)'(RX_DEPTH);
  wire rx_any   = rx_cnt != '0;
  wire rx_out   = data_rd & rx_any;
  wire rx_flush = acc_wr & addr == 3'd2 & wdata[0] & wdata[1];
  wire rx_take  = rx_push & (~rx_full | rx_out);

  assign tx_empty = tx_cnt == '0;
  assign tx_data  = tx_mem[tx_rp];

  logic [7:0] cause;
  always_comb begin
    if (ovr_q && ier_q[2])       cause = C_LINE;
    else if (rx_any && ier_q[0]) cause = C_RXD;
    else if (thre_q && ier_q[1]) cause = C_THRE;
    else                         cause = C_NONE;
  end
  assign irq = (cause != C_NONE) ^ irq_pol_low;

  always_ff @(posedge clk) if (tx_wr) tx_mem[tx_wp] <= wdata;
  always_ff @(posedge clk) if (rx_take && !rx_flush) rx_mem[rx_wp] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_wr) tx_wp <= tx_wp + 1'b1;
      if (tx_out || tx_drop) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + (TXW+1)'(tx_inc) - (TXW+1)'(tx_out);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_take) rx_wp <= rx_wp + 1'b1;
      if (rx_out) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + (RXW+1)'(rx_take) - (RXW+1)'(rx_out);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll_q <= DIV0[7:0]; dlm_q <= DIV0[15:8];
      lcr_q <= '0; scr_q <= '0; fcr_q <= '0; ier_q <= '0;
      ovr_q <= 1'b0; thre_q <= 1'b0;
    end else begin
      if (acc_wr) begin
        unique case (addr)
          3'd0: if (dlab) dll_q <= wdata; else thre_q <= 1'b1;
          3'd1: if (dlab) dlm_q <= wdata; else ier_q <= wdata[3:0];
          3'd2: fcr_q <= wdata[0] ? (wdata & 8'hC9) : 8'h00;
          3'd3: lcr_q <= wdata;
          3'd7: scr_q <= wdata;
          default: ;
        endcase
      end
      if (acc_rd) begin
        if ((addr == 3'd0 && !dlab) || addr == 3'd5) ovr_q <= 1'b0;
        if (addr == 3'd2 && cause == C_THRE) thre_q <= 1'b0;
      end
      if (rx_push && !rx_take && !rx_flush) ovr_q <= 1'b1;
    end
  end

  logic [7:0] rd_mux;
  always_comb begin
    unique case (addr)
      3'd0: rd_mux = dlab ? dll_q : (rx_any ? rx_mem[rx_rp] : 8'hFF);
      3'd1: rd_mux = dlab ? dlm_q : {4'h0, ier_q};
      3'd2: rd_mux = (fcr_q[0] ? 8'hC0 : 8'h00) | cause;
      3'd3: rd_mux = lcr_q;
      3'd5: rd_mux = {1'b0, 2'b11, 3'b000, ovr_q, rx_any};
      3'd7: rd_mux = scr_q;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (acc_rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       wr,
  input logic       rd,
  input logic [2:0] addr,
  input logic [7:0] rdata,
  input logic       irq,
  input logic       irq_pol_low,
  input logic [3:0] ier_q,
  input logic [7:0] fcr_q,
  input logic [7:0] lcr_q,
  input logic       rx_any,
  input logic       rx_full,
  input logic       rx_push,
  input logic       ovr_q
);
  wire rd_now = sel && rd && !wr;

  AST_IER_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now && addr == 3'd1 && !lcr_q[7] |=> rdata[7:4] == 4'h0); // R3
  AST_IIR_FIFO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now && addr == 3'd2 |=> rdata[7:6] == ($past(fcr_q[0]) ? 2'b11 : 2'b00)); // R6
  AST_LSR_TX_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now && addr == 3'd5 |=> rdata[6:5] == 2'b11); // R8
  AST_RBR_EMPTY_FF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now && addr == 3'd0 && !lcr_q[7] && !rx_any |=> rdata == 8'hFF); // R7
  AST_IRQ_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ier_q == 4'h0 |-> irq == irq_pol_low); // R10
  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full && !sel |=> ovr_q); // R12
endmodule

bind uart_regfront uart_regfront_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .addr(addr),
  .rdata(rdata), .irq(irq), .irq_pol_low(irq_pol_low), .ier_q(ier_q),
  .fcr_q(fcr_q), .lcr_q(lcr_q), .rx_any(rx_any), .rx_full(rx_full),
  .rx_push(rx_push), .ovr_q(ovr_q)
);

// File: tb/sim_uart_regfront.sv
module sim_uart_regfront;
  logic clk = 0, rst_n = 0, pol = 0;
  logic sel = 0, wr = 0, rd = 0, tx_pop = 0, rx_push = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rx_byte = 0;
  logic [7:0] rdata, tx_data;
  logic irq, tx_empty;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic mon_due = 0;

  always #10 clk = ~clk;

  uart_regfront u0 (
    .clk(clk), .rst_n(rst_n), .irq_pol_low(pol), .sel(sel), .wr(wr), .rd(rd),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .tx_pop(tx_pop),
    .tx_data(tx_data), .tx_empty(tx_empty), .rx_push(rx_push), .rx_byte(rx_byte)
  );

  function automatic void check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endfunction

  always @(posedge clk) mon_due <= sel & rd & ~wr;
  always @(negedge clk) if (mon_due && exp_q.size() > 0) begin
    automatic logic [7:0] e = exp_q.pop_front();
    automatic string t = tag_q.pop_front();
    check(rdata == e, t, rdata, e);
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); sel = 1; rd = 1; addr = a;
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_byte = b;
    @(negedge clk); rx_push = 0;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(irq == 1'b0, "R10 reset irq", irq, 0);
    check(tx_empty == 1'b1, "R2 reset tx_empty", tx_empty, 1);
    rd_reg(3, 8'h00, "R11 reset lcr");
    wr_reg(3, 8'h80);
    rd_reg(0, 8'h0C, "R11 reset dll");
    rd_reg(1, 8'h00, "R11 reset dlm");
    wr_reg(0, 8'h34); wr_reg(1, 8'h12);
    rd_reg(0, 8'h34, "R1 dll rw");
    rd_reg(1, 8'h12, "R1 dlm rw");
    check(tx_empty == 1'b1, "R1 dll write not queued", tx_empty, 1);
    wr_reg(3, 8'h03);
    rd_reg(1, 8'h00, "R1 ier untouched");
    rd_reg(3, 8'h03, "R1 lcr readback");
    rd_reg(0, 8'hFF, "R7 empty rbr");
    wr_reg(1, 8'hFF);
    rd_reg(1, 8'h0F, "R3 ier mask");
    wr_reg(1, 8'h00);
    wr_reg(0, 8'h41); wr_reg(0, 8'h42);
    check(tx_empty == 1'b0 && tx_data == 8'h41, "R2 tx head", tx_data, 8'h41);
    @(negedge clk); tx_pop = 1; @(negedge clk); tx_pop = 0;
    check(tx_data == 8'h42, "R2 tx pop", tx_data, 8'h42);
    rd_reg(2, 8'h01, "R5 none pending");
    wr_reg(1, 8'h02);
    check(irq == 1'b1, "R10 thre irq", irq, 1);
    rd_reg(2, 8'h02, "R6 iir thre");
    rd_reg(2, 8'h01, "R6 thre cleared");
    check(irq == 1'b0, "R10 irq released", irq, 0);
    wr_reg(2, 8'h01);
    rd_reg(2, 8'hC1, "R4 fifo enable");
    wr_reg(2, 8'hFF);
    rd_reg(2, 8'hC1, "R4 fifo stays enabled");
    wr_reg(2, 8'h00);
    rd_reg(2, 8'h01, "R4 fifo disable");
    wr_reg(1, 8'h01);
    push_rx(8'h55);
    check(irq == 1'b1, "R10 rx irq", irq, 1);
    rd_reg(2, 8'h0C, "R5 rx cause");
    rd_reg(5, 8'h61, "R8 lsr data ready");
    rd_reg(0, 8'h55, "R7 rbr pop");
    rd_reg(5, 8'h60, "R8 lsr idle");
    check(irq == 1'b0, "R10 rx irq gone", irq, 0);
    push_rx(8'h66); push_rx(8'h77);
    wr_reg(2, 8'h03);
    rd_reg(5, 8'h60, "R4 rx flush");
    wr_reg(2, 8'h00);
    for (int i = 0; i < 17; i++) push_rx(8'(8'h10 + i));
    wr_reg(1, 8'h05);
    rd_reg(2, 8'h06, "R5 overrun first");
    rd_reg(5, 8'h63, "R12 overrun set");
    rd_reg(5, 8'h61, "R8 lsr clears overrun");
    rd_reg(2, 8'h0C, "R5 rx after overrun");
    rd_reg(0, 8'h10, "R12 oldest kept");
    push_rx(8'h30); push_rx(8'h31);
    rd_reg(0, 8'h11, "R7 rbr second");
    rd_reg(5, 8'h61, "R7 rbr clears overrun");
    wr_reg(2, 8'h03); wr_reg(2, 8'h00);
    wr_reg(1, 8'h03);
    wr_reg(0, 8'h99);
    push_rx(8'h01);
    rd_reg(2, 8'h0C, "R5 rx over thre");
    rd_reg(0, 8'h01, "R7 rbr byte");
    rd_reg(2, 8'h02, "R5 thre after rx");
    rd_reg(2, 8'h01, "R6 thre cleared again");
    rd_reg(6, 8'h00, "R9 msr zero");
    wr_reg(4, 8'hFF);
    rd_reg(4, 8'h00, "R9 mcr ignored");
    wr_reg(5, 8'hFF); wr_reg(6, 8'hFF);
    rd_reg(5, 8'h60, "R9 lsr write ignored");
    wr_reg(7, 8'hA5);
    rd_reg(7, 8'hA5, "R9 scratch");
    wr_reg(1, 8'h00);
    @(negedge clk); pol = 1; @(negedge clk);
    check(irq == 1'b1, "R10 low-active idle", irq, 1);
    wr_reg(1, 8'h02); wr_reg(0, 8'h5A);
    check(irq == 1'b0, "R10 low-active asserted", irq, 0);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule